// File: doc/BRIEF.md
# High-Speed Chirp Negotiation Controller

This block is the device-side controller that runs while the upstream port holds the bus in reset. It decides whether the link moves to high speed or stays at full speed. It samples a two-bit line state that a transceiver has already synchronized to the local clock. It recognizes a host reset from a sustained run of single-ended zero. It then requests a chirp K from the transmitter for a programmed number of cycles. After that it listens for the host's answer, which is a sequence of alternating K and J chirps.

Every line level must stay unchanged for a programmed dwell before the block accepts it, so short glitches are never counted. If the required number of complete K-then-J pairs arrives inside a programmed listening window, the block selects high-speed terminations, drops the full-speed pull-up and raises its high-speed flag. It holds that mode until it sees the next reset. Otherwise it keeps the full-speed pull-up. It waits for the reset to end and then returns to idle.

Top module: `hs_chirp_neg`

## Requirements
- R1: During and right after reset (rst_n low, synchronous), fs_pullup_en is 1 and chirp_k_tx, hs_term_en and hs_mode are 0. The line encoding is 2'b00 single-ended zero, 2'b01 J, 2'b10 K and 2'b11 single-ended one.
- R2: From idle, chirp_k_tx rises on the clock edge that follows the DWELL_CYC-th consecutive single-ended-zero sample. A run of fewer samples, ended by any other level, starts no chirp.
- R3: chirp_k_tx stays high for exactly CHIRP_CYC clock cycles and then falls, which starts the listening window.
- R4: A host K or J counts only after DWELL_CYC consecutive samples at that level. A shorter K or J does not advance the pair count.
- R5: A pair is a qualified K followed by a qualified J, and levels out of order are skipped. Once PAIRS_REQ pairs are counted, hs_mode and hs_term_en rise and fs_pullup_en falls two clock edges after the DWELL_CYC-th sample of the last J.
- R6: With fewer than PAIRS_REQ pairs the outputs stay at full speed.
- R7: The pairs must complete within WAIT_CYC cycles of the start of the listening window. If success and expiry fall on the same edge, success wins. After expiry, further chirps cannot raise hs_mode.
- R8: After a failed negotiation, single-ended zero that continues does not start a new chirp. The first sample at any other level returns the block to idle, and from there a fresh qualified run of single-ended zero chirps again.
- R9: High-speed mode holds through any line activity that is not a qualified reset. A qualified run of single-ended zero leaves high speed and starts a new chirp on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, e.g. 60 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| line_st | input | 2 | Synchronized line state (00 SE0, 01 J, 10 K, 11 SE1) |
| chirp_k_tx | output | 1 | Request to drive chirp K |
| fs_pullup_en | output | 1 | Full-speed pull-up enable |
| hs_term_en | output | 1 | High-speed termination enable |
| hs_mode | output | 1 | High-speed mode flag |

## Verification
The bench builds the block with DWELL_CYC=4, CHIRP_CYC=12, WAIT_CYC=60 and PAIRS_REQ=3. With these values it can sweep every glitch length from one sample up to one short of the dwell, for the reset run, for host K and for host J. It can also walk pair counts from zero to the required number. With a 60-cycle window the bench can place the final pair so that it completes on the last edge before expiry and on the first edge after it. The expected outcome of each case is computed from the dwell and pair arithmetic.

// File: rtl/hs_neg_pkg.sv
// Shared types for the chirp negotiation controller.
// Assumes the transceiver delivers line state already synchronized to clk.
package hs_neg_pkg;

    // Line state encoding as seen from the transceiver
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    // Negotiation phases
    typedef enum logic [2:0] {
        ST_FS_IDLE = 3'd0,
        ST_CHIRP   = 3'd1,
        ST_LISTEN  = 3'd2,
        ST_FS_HOLD = 3'd3,
        ST_HS      = 3'd4
    } neg_st_e;

endpackage

// File: rtl/hs_neg_dwell.sv
// Dwell qualifier: counts how many consecutive samples the line has held
// one level and flags the level as settled once the run reaches DWELL_CYC.
// Assumes DWELL_CYC >= 2. The run counter saturates at DWELL_CYC.
module hs_neg_dwell #(
    parameter int DWELL_CYC = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_i,
    output logic       settled_o,
    output logic [1:0] settled_line_o
);
    localparam int CW = $clog2(DWELL_CYC + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(DWELL_CYC);

    logic [1:0]    last_q;
    logic [CW-1:0] run_q;

    // Track the previous sample and the length of the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 2'b11;
            run_q  <= '0;
        end else begin
            last_q <= line_i;
            if (line_i != last_q) begin
                run_q <= CW'(1);
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign settled_o      = (run_q == RUN_MAX);
    assign settled_line_o = last_q;

    // Run length never exceeds the dwell
    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    // Settling is reached only by one more matching sample
    p_settle_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> ($past(run_q) == RUN_MAX - 1'b1) && ($past(line_i) == last_q));

endmodule

// File: rtl/hs_neg_timer.sv
// Phase timer: counts cycles since the last clear and saturates at all ones.
// Assumes the controller clears it on every phase change.
module hs_neg_timer #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Count elapsed cycles in the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // After a clear the count restarts from zero
    p_timer_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> cnt_q == '0);

endmodule

// File: rtl/hs_neg_pairs.sv
// Pair tracker: waits for a settled K, then a settled J, and counts each
// such pair. It stops at PAIRS_REQ. It is held cleared outside the listening phase.
// Out-of-order levels are skipped and do not reset progress.
module hs_neg_pairs #(
    parameter int PAIRS_REQ = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic k_ok_i,
    input  logic j_ok_i,
    output logic done_o
);
    localparam int PW = $clog2(PAIRS_REQ + 1);
    localparam logic [PW-1:0] GOAL = PW'(PAIRS_REQ);

    logic          want_j_q;
    logic [PW-1:0] cnt_q;

    // Alternate between waiting for K and waiting for J, counting full pairs
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            want_j_q <= 1'b0;
            cnt_q    <= '0;
        end else if (cnt_q != GOAL) begin
            if (!want_j_q && k_ok_i) begin
                want_j_q <= 1'b1;
            end else if (want_j_q && j_ok_i) begin
                want_j_q <= 1'b0;
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = (cnt_q == GOAL);

    // Pair count never passes the goal
    p_pair_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GOAL);

    // The count advances only on a settled J that follows a settled K
    p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_i) && cnt_q != $past(cnt_q)) |-> ($past(want_j_q) && $past(j_ok_i)));

endmodule

// File: rtl/hs_chirp_neg.sv
// Chirp negotiation controller, top level.
// It detects a host reset from settled SE0 and requests chirp K for CHIRP_CYC
// cycles. It then listens up to WAIT_CYC cycles for PAIRS_REQ host K/J pairs.
// On success it commits to high speed until the next reset. On failure it
// keeps full speed and returns to idle once SE0 ends.
// Assumes line_st is synchronous to clk and WAIT_CYC ends before the reset does.
module hs_chirp_neg
    import hs_neg_pkg::*;
#(
    parameter int DWELL_CYC = 150,
    parameter int CHIRP_CYC = 60000,
    parameter int WAIT_CYC  = 420000,
    parameter int PAIRS_REQ = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    output logic       chirp_k_tx,
    output logic       fs_pullup_en,
    output logic       hs_term_en,
    output logic       hs_mode
);
    localparam int TMAX = (CHIRP_CYC > WAIT_CYC) ? CHIRP_CYC : WAIT_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] CHIRP_LAST = TW'(CHIRP_CYC - 1);
    localparam logic [TW-1:0] WAIT_LAST  = TW'(WAIT_CYC - 1);

    neg_st_e       state_q, state_d;
    logic          settled;
    logic [1:0]    settled_line;
    logic [TW-1:0] tmr_cnt;
    logic          se0_rst, k_ok, j_ok, pairs_done;

    hs_neg_dwell #(.DWELL_CYC(DWELL_CYC)) dwell_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_i         (line_st),
        .settled_o      (settled),
        .settled_line_o (settled_line)
    );

    assign se0_rst = settled && (settled_line == LN_SE0);
    assign k_ok    = settled && (settled_line == LN_K);
    assign j_ok    = settled && (settled_line == LN_J);

    hs_neg_timer #(.W(TW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .cnt_o (tmr_cnt)
    );

    hs_neg_pairs #(.PAIRS_REQ(PAIRS_REQ)) pairs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_LISTEN),
        .k_ok_i (k_ok),
        .j_ok_i (j_ok),
        .done_o (pairs_done)
    );

    // Choose the next negotiation phase
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FS_IDLE: if (se0_rst) state_d = ST_CHIRP;
            ST_CHIRP:   if (tmr_cnt == CHIRP_LAST) state_d = ST_LISTEN;
            ST_LISTEN: begin
                if (pairs_done)                  state_d = ST_HS;
                else if (tmr_cnt == WAIT_LAST)   state_d = ST_FS_HOLD;
            end
            ST_FS_HOLD: if (line_st != LN_SE0) state_d = ST_FS_IDLE;
            ST_HS:      if (se0_rst) state_d = ST_CHIRP;
            default:    state_d = ST_FS_IDLE;
        endcase
    end

    // Register the phase
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FS_IDLE;
        else        state_q <= state_d;
    end

    assign chirp_k_tx   = (state_q == ST_CHIRP);
    assign hs_mode      = (state_q == ST_HS);
    assign hs_term_en   = (state_q == ST_HS);
    assign fs_pullup_en = (state_q != ST_HS);

    // A chirp starts only after a qualified reset
    p_chirp_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_k_tx) |-> $past(se0_rst));

    // A chirp ends only when the timer reaches the programmed length
    p_chirp_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_k_tx) |-> $past(tmr_cnt) == CHIRP_LAST);

    // High speed is entered only from listening with enough pairs
    p_hs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ($past(state_q) == ST_LISTEN) && $past(pairs_done));

    // An expired window without pairs never leads to high speed
    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN && tmr_cnt == WAIT_LAST && !pairs_done) |=> !hs_mode);

    // High speed holds until a qualified reset
    p_hs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && !se0_rst) |=> hs_mode);

    // Ongoing SE0 after failure must not restart a chirp
    p_hold_no_chirp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FS_HOLD) |=> !chirp_k_tx);

endmodule

// File: tb/hs_chirp_neg_tb_top.sv
module hs_chirp_neg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 4;
    localparam int CH = 12;
    localparam int WT = 60;
    localparam int NP = 3;

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] LJ  = 2'b01;
    localparam logic [1:0] LK  = 2'b10;
    localparam logic [1:0] SE1 = 2'b11;

    logic       clk;
    logic       rst_n;
    logic [1:0] line_st;
    logic       chirp_k_tx, fs_pullup_en, hs_term_en, hs_mode;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    hs_chirp_neg #(
        .DWELL_CYC (D),
        .CHIRP_CYC (CH),
        .WAIT_CYC  (WT),
        .PAIRS_REQ (NP)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_st      (line_st),
        .chirp_k_tx   (chirp_k_tx),
        .fs_pullup_en (fs_pullup_en),
        .hs_term_en   (hs_term_en),
        .hs_mode      (hs_mode)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Hold a line level for n sampling edges; returns at a falling edge
    task automatic drive(logic [1:0] l, int n);
        line_st = l;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_speed(string tag, int hs);
        check(tag, hs_mode, hs);
        check(tag, hs_term_en, hs);
        check(tag, fs_pullup_en, 1 - hs);
    endtask

    // Bring the block to idle or high speed, then run reset and chirp (R2, R3)
    task automatic go_listen();
        drive(LJ, WT + 2);
        drive(SE0, D);
        check("R2 no chirp before dwell", chirp_k_tx, 0);
        drive(SE0, 1);
        check("R2 chirp after dwell", chirp_k_tx, 1);
        check_speed("R9 chirp uses fs", 0);
        drive(SE0, CH - 1);
        check("R3 chirp still on", chirp_k_tx, 1);
        drive(SE0, 1);
        check("R3 chirp released", chirp_k_tx, 0);
    endtask

    task automatic pair(int kl, int jl);
        drive(LK, kl);
        drive(LJ, jl);
    endtask

    initial begin
        line_st = LJ;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset chirp", chirp_k_tx, 0);
        check_speed("R1 reset speed", 0);
        rst_n = 1'b1;
        drive(LJ, 2);
        check("R1 after reset chirp", chirp_k_tx, 0);
        check_speed("R1 after reset speed", 0);

        // R2: every SE0 run shorter than the dwell is ignored
        for (int g = 1; g < D; g++) begin
            drive(LJ, 2);
            drive(SE0, g);
            drive(LJ, 3);
            check("R2 short se0", chirp_k_tx, 0);
        end

        // R5/R6: sweep the number of full pairs
        for (int n = 0; n <= NP; n++) begin
            go_listen();
            for (int p = 0; p < n; p++) pair(D, D);
            drive(LJ, 1);
            check_speed("R5 not yet", 0);
            drive(LJ, 1);
            check_speed((n >= NP) ? "R5 pairs done" : "R6 too few pairs", (n >= NP) ? 1 : 0);
        end

        // R4: short K glitch does not count
        for (int g = 1; g < D; g++) begin
            go_listen();
            for (int p = 0; p < NP - 1; p++) pair(D, D);
            pair(g, D);
            drive(LJ, 2);
            check_speed("R4 short K ignored", 0);
            pair(D, D);
            drive(LJ, 2);
            check_speed("R4 good pair after glitch", 1);
        end

        // R4: short J glitch does not count
        for (int g = 1; g < D; g++) begin
            go_listen();
            for (int p = 0; p < NP - 1; p++) pair(D, D);
            drive(LK, D);
            drive(LJ, g);
            drive(LK, D + 2);
            check_speed("R4 short J ignored", 0);
            drive(LJ, D + 2);
            check_speed("R4 good J after glitch", 1);
        end

        // R7: last pair lands on the last edge of the window and one edge later
        for (int m = WT - NP * 2 * D - 2; m <= WT - NP * 2 * D - 1; m++) begin
            go_listen();
            drive(SE0, m);
            for (int p = 0; p < NP; p++) pair(D, D);
            drive(LJ, 2);
            check_speed("R7 window boundary", (m + NP * 2 * D + 2 <= WT) ? 1 : 0);
        end

        // R7/R8: expiry with SE0 continuing, no re-chirp, then release to idle
        go_listen();
        drive(SE0, WT + D + 3);
        check("R8 no chirp while se0 continues", chirp_k_tx, 0);
        check_speed("R7 expired stays fs", 0);
        drive(LJ, 1);
        drive(SE0, D);
        check("R8 idle needs full dwell", chirp_k_tx, 0);
        drive(SE0, 1);
        check("R8 chirp after return to idle", chirp_k_tx, 1);
        drive(SE0, CH);
        for (int p = 0; p < NP; p++) pair(D, D);
        drive(LJ, 2);
        check_speed("R8 renegotiated", 1);

        // R9: high speed holds through activity and short SE0
        for (int g = 1; g < D; g++) begin
            drive(LK, g + 2);
            drive(SE1, g);
            drive(SE0, g);
            drive(LJ, 3 * D);
            check_speed("R9 hold", 1);
            check("R9 no chirp", chirp_k_tx, 0);
        end
        drive(SE0, D);
        check_speed("R9 hs until dwell", 1);
        drive(SE0, 1);
        check_speed("R9 reset leaves hs", 0);
        check("R9 reset chirps", chirp_k_tx, 1);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule